// File: doc/BRIEF.md
# Paged program address extender

This block widens the 16-bit in-page address from a program address generator into a 23-bit program fetch address. The upper 7 bits come from a page register. Program space holds 128 pages of 64K words each. Software reads and writes the page register through a small data-space register port at one fixed word address.

For every fetch request, the block decides whether on-chip ROM serves the fetch or whether it goes out as an external access. On-chip ROM is the low `ROM_WORDS` words of the 23-bit space. The default is 128K words, and a 64K-word variant is selected by the parameter.

A mode pin is sampled as reset is released. It decides whether the ROM is mapped at all. Whatever the pin value, the first fetch after reset goes to in-page address 0xFF80 in page 0.

Top module: `prog_page_ext`

## Requirements
- R1: Apart from the first fetch after reset, `paddr_o` equals the page register in bits [22:16] concatenated with `pc_ofs_i` in bits [15:0].
- R2: The page register sits at data word address 0x001E. A write there keeps only `dwdata_i[6:0]`. A read there returns the page zero-extended to 16 bits. Any other address reads as 0, and a write to any other address leaves the page unchanged.
- R3: Reset clears the page register to 0.
- R4: A page write updates the fetch address from the next cycle on. A fetch in the same cycle as the write still uses the old page.
- R5: A fetch asserts `onchip_sel_o` when the ROM is mapped and `paddr_o` is below `ROM_WORDS`. In every other case it asserts `ext_strobe_o`.
- R6: In a cycle with `fetch_req_i` high outside reset, exactly one of `onchip_sel_o` and `ext_strobe_o` is high. Both are low when there is no request and while `rst_n` is low.
- R7: The first fetch after reset drives `paddr_o` = 0x00FF80, whatever `pc_ofs_i` and the page register hold.
- R8: The value of `mode_n_i` at the first rising clock edge with `rst_n` high selects the ROM mapping. Low maps the ROM. High unmaps it, so that every fetch is external. The same value already applies to a fetch in the cycle before that edge.
- R9: After it has been latched, `mode_n_i` has no effect until the next reset.
- R10: `ROM_WORDS` sets the on-chip boundary. With 131072, address 0x01FFFF is on-chip and 0x020000 is external. With 65536, address 0x00FFFF is on-chip and 0x010000 is external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| mode_n_i | input | 1 | Mapping mode pin, sampled on the edge where reset is released (low = ROM mapped) |
| fetch_req_i | input | 1 | Program fetch request for this cycle |
| pc_ofs_i | input | 16 | In-page address from the program address generator |
| paddr_o | output | 23 | Extended program fetch address |
| onchip_sel_o | output | 1 | Fetch served by on-chip ROM |
| ext_strobe_o | output | 1 | Fetch sent to the external bus |
| daddr_i | input | 16 | Data-space register address |
| dwe_i | input | 1 | Data-space write enable |
| dwdata_i | input | 16 | Data-space write data |
| drdata_o | output | 16 | Data-space read data |

## Verification
Two functions can act in the same cycle: a page write and a fetch. The bench provokes this for every one of the 128 pages. Each page value is written with garbage in its upper bits, and a fetch is issued in the same cycle. The bench then expects the old page on `paddr_o` and on the read port, and expects the new page from the following cycle on.

The reset-vector fetch and a page write made before it form a second coincidence. The bench writes a nonzero page first and then expects the vector address, followed by the written page on the next fetch. The ROM-mapping decision is judged against the arithmetic boundary on two instances, one with 128K words and one with 64K words.

// File: rtl/prog_page_ext.sv
module prog_page_ext #(
  parameter int PAGE_W    = 7,
  parameter int OFS_W     = 16,
  parameter int DATA_W    = 16,
  parameter int DADDR_W   = 16,
  parameter int ROM_WORDS = 131072,
  parameter logic [15:0] PAGE_ADDR = 16'h001E,
  parameter logic [15:0] BOOT_OFS  = 16'hFF80
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_n_i,
  input  logic                      fetch_req_i,
  input  logic [OFS_W-1:0]          pc_ofs_i,
  output logic [PAGE_W+OFS_W-1:0]   paddr_o,
  output logic                      onchip_sel_o,
  output logic                      ext_strobe_o,
  input  logic [DADDR_W-1:0]        daddr_i,
  input  logic                      dwe_i,
  input  logic [DATA_W-1:0]         dwdata_i,
  output logic [DATA_W-1:0]         drdata_o
);
  localparam int PA_W = PAGE_W + OFS_W;

  logic [PAGE_W-1:0] page_q;
  logic              in_rst_q;
  logic              boot_q;
  logic              map_q;
  logic              page_hit;
  logic              map_now;
  logic              req;
  logic              in_rom;
  logic              unused_hi;

  assign page_hit  = daddr_i == DADDR_W'(PAGE_ADDR);
  assign map_now   = in_rst_q ? ~mode_n_i : map_q;
  assign req       = fetch_req_i & rst_n;
  assign unused_hi = ^dwdata_i[DATA_W-1:PAGE_W];

  assign paddr_o = boot_q ? PA_W'(BOOT_OFS) : {page_q, pc_ofs_i};
  assign in_rom  = {1'b0, paddr_o} < (PA_W+1)'(ROM_WORDS);

  assign onchip_sel_o = req &  (map_now & in_rom);
  assign ext_strobe_o = req & ~(map_now & in_rom);

  assign drdata_o = page_hit ? DATA_W'(page_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      in_rst_q <= 1'b1;
      boot_q   <= 1'b1;
      map_q    <= 1'b0;
    end else begin
      in_rst_q <= 1'b0;
      if (in_rst_q)
        map_q <= ~mode_n_i;
      if (fetch_req_i)
        boot_q <= 1'b0;
      if (dwe_i && page_hit)
        page_q <= dwdata_i[PAGE_W-1:0];
    end
  end
endmodule

module prog_page_ext_chk #(
  parameter int PAGE_W    = 7,
  parameter int OFS_W     = 16,
  parameter int DATA_W    = 16,
  parameter int DADDR_W   = 16,
  parameter int ROM_WORDS = 131072,
  parameter logic [15:0] PAGE_ADDR = 16'h001E,
  parameter logic [15:0] BOOT_OFS  = 16'hFF80
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_req_i,
  input logic [PAGE_W+OFS_W-1:0] paddr_o,
  input logic                    onchip_sel_o,
  input logic                    ext_strobe_o,
  input logic [DADDR_W-1:0]      daddr_i,
  input logic                    dwe_i,
  input logic [DATA_W-1:0]       dwdata_i,
  input logic [DATA_W-1:0]       drdata_o
);
  localparam int PA_W = PAGE_W + OFS_W;

  assert_one_of_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({onchip_sel_o, ext_strobe_o}) == (fetch_req_i ? 1 : 0));

  assert_ext_beyond_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_i && ({1'b0, paddr_o} >= (PA_W+1)'(ROM_WORDS))) |-> ext_strobe_o);

  assert_zero_extend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (daddr_i == DADDR_W'(PAGE_ADDR)) |-> (drdata_o[DATA_W-1:PAGE_W] == '0));

  assert_write_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dwe_i && (daddr_i == DADDR_W'(PAGE_ADDR))) &&
     (daddr_i == DADDR_W'(PAGE_ADDR)))
    |-> (drdata_o == DATA_W'($past(dwdata_i[PAGE_W-1:0]))));

  assert_boot_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && fetch_req_i) |-> (paddr_o == PA_W'(BOOT_OFS)));

  assert_page_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && (daddr_i == DADDR_W'(PAGE_ADDR))) |-> (drdata_o == '0));
endmodule

bind prog_page_ext prog_page_ext_chk #(
  .PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .DADDR_W(DADDR_W),
  .ROM_WORDS(ROM_WORDS), .PAGE_ADDR(PAGE_ADDR), .BOOT_OFS(BOOT_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_req_i(fetch_req_i), .paddr_o(paddr_o),
  .onchip_sel_o(onchip_sel_o), .ext_strobe_o(ext_strobe_o), .daddr_i(daddr_i),
  .dwe_i(dwe_i), .dwdata_i(dwdata_i), .drdata_o(drdata_o)
);

// File: tb/prog_page_ext_tb.sv
module prog_page_ext_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_A = 131072;
  localparam int ROM_B = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_n = 1'b0;
  logic fetch = 1'b0;
  logic dwe = 1'b0;
  logic [15:0] pc = '0;
  logic [15:0] daddr = '0;
  logic [15:0] dwdata = '0;

  logic [22:0] pa_a, pa_b;
  logic sel_a, ext_a, sel_b, ext_b;
  logic [15:0] rd_a, rd_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] page_m = '0;
  bit mapped_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_page_ext #(.ROM_WORDS(ROM_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_n_i(mode_n), .fetch_req_i(fetch), .pc_ofs_i(pc),
    .paddr_o(pa_a), .onchip_sel_o(sel_a), .ext_strobe_o(ext_a),
    .daddr_i(daddr), .dwe_i(dwe), .dwdata_i(dwdata), .drdata_o(rd_a));

  prog_page_ext #(.ROM_WORDS(ROM_B)) dut64_i (
    .clk(clk), .rst_n(rst_n), .mode_n_i(mode_n), .fetch_req_i(fetch), .pc_ofs_i(pc),
    .paddr_o(pa_b), .onchip_sel_o(sel_b), .ext_strobe_o(ext_b),
    .daddr_i(daddr), .dwe_i(dwe), .dwdata_i(dwdata), .drdata_o(rd_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit f, input logic [15:0] ofs, input bit we,
                      input logic [15:0] wa, input logic [15:0] wd);
    @(negedge clk);
    fetch = f; pc = ofs; dwe = we; daddr = wa; dwdata = wd;
    #1;
  endtask

  task automatic expect_fetch(input string tag, input logic [22:0] a);
    chk(tag, 32'(pa_a), 32'(a));
    chk(tag, 32'(pa_b), 32'(a));
    chk(tag, 32'({sel_a, ext_a}), (mapped_m && (32'(a) < ROM_A)) ? 32'd2 : 32'd1);
    chk(tag, 32'({sel_b, ext_b}), (mapped_m && (32'(a) < ROM_B)) ? 32'd2 : 32'd1);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; mode_n = m; fetch = 1'b1; pc = 16'h0100; dwe = 1'b0; daddr = 16'h001E;
    #1 chk("R6 no select during reset", 32'({sel_a, ext_a, sel_b, ext_b}), 32'd0);
    repeat (2) @(negedge clk);
    fetch = 1'b0; rst_n = 1'b1;
    #1 chk("R3 page cleared", 32'(rd_a), 32'd0);
    @(posedge clk);
    #1 mode_n = ~m;
    page_m = '0;
    mapped_m = !m;
  endtask

  task automatic boot_check();
    step(0, 16'h1234, 1, 16'h001E, 16'h0005);
    page_m = 7'd5;
    step(1, 16'h1234, 0, 16'h001E, 16'h0000);
    expect_fetch("R7 boot vector", 23'h00FF80);
    step(1, 16'h1234, 0, 16'h001E, 16'h0000);
    expect_fetch("R7 R1 after boot", {page_m, 16'h1234});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ofs_l [4];
    ofs_l[0] = 16'h0000; ofs_l[1] = 16'h7FFF; ofs_l[2] = 16'hFF80; ofs_l[3] = 16'hFFFF;

    do_reset(1'b0);
    boot_check();

    for (int p = 0; p < 128; p++) begin
      step(1, 16'hFFFF, 1, 16'h001E, 16'hFE00 | 16'(p));
      expect_fetch("R4 same-cycle fetch uses old page", {page_m, 16'hFFFF});
      chk("R4 read before update", 32'(rd_a), 32'(page_m));
      page_m = 7'(p);
      for (int k = 0; k < 4; k++) begin
        step(1, ofs_l[k], 0, 16'h001E, 16'h0000);
        expect_fetch("R1 R5 R10 sweep", {page_m, ofs_l[k]});
        chk("R2 zero-extended readback", 32'(rd_a), 32'(p));
      end
      step(0, 16'h0000, 0, 16'h001E, 16'h0000);
      chk("R6 idle", 32'({sel_a, ext_a, sel_b, ext_b}), 32'd0);
    end

    step(1, 16'h0040, 1, 16'h001F, 16'h0055);
    chk("R2 other address reads 0", 32'(rd_a), 32'd0);
    step(1, 16'h0040, 0, 16'h001E, 16'h0000);
    chk("R2 other address write ignored", 32'(rd_a), 32'(page_m));
    expect_fetch("R2 page unchanged", {page_m, 16'h0040});

    step(0, 16'h0000, 1, 16'h001E, 16'h0001);
    page_m = 7'd1;
    step(1, 16'hFFFF, 0, 16'h001E, 16'h0000);
    expect_fetch("R10 last on-chip word", 23'h01FFFF);
    step(0, 16'h0000, 1, 16'h001E, 16'h0002);
    page_m = 7'd2;
    step(1, 16'h0000, 0, 16'h001E, 16'h0000);
    expect_fetch("R10 first external word", 23'h020000);

    do_reset(1'b1);
    boot_check();
    step(0, 16'h0000, 1, 16'h001E, 16'h0000);
    page_m = 7'd0;
    for (int k = 0; k < 4; k++) begin
      step(1, ofs_l[k], 0, 16'h001E, 16'h0000);
      expect_fetch("R8 unmapped all external R9 pin toggled", {page_m, ofs_l[k]});
    end

    do_reset(1'b0);
    step(1, 16'h0010, 0, 16'h001E, 16'h0000);
    expect_fetch("R7 R8 boot vector mapped", 23'h00FF80);
    step(1, 16'h0010, 0, 16'h001E, 16'h0000);
    expect_fetch("R9 pin high after latch ignored", 23'h000010);

    step(0, 16'h0000, 0, 16'h0000, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule